// File: doc/BRIEF.md
# Quad-Channel Pulse-Width Modulator with Register Port

The block produces four independent pulse-width-modulated outputs that software controls through a 32-bit register port. Every channel owns a 16-bit down-counter. The counter advances only on that channel's tick input, which an external prescaler supplies. When the counter reaches zero it reloads from the channel's period register. The output is high for a number of ticks set by the channel's compare register. An invert bit per channel complements the output.

Software first writes the period and compare values for a channel. It then sets the channel's enable and continuous-mode bits in the shared control register. A channel with either bit clear does not count, and its output rests at its idle level. A new period or compare value waits for the next counter reload, so a running waveform never shows a truncated cycle. The register port stores the prescale and clock-select words so software can read them back. The interrupt and watchdog-data locations exist in the map but hold no state.

Top module: `pwmq_ctrl`

## Requirements
- R1: After reset every register location reads 0 and all four outputs are 0.
- R2: A period or compare write whose value exceeds 65535 stores 65535. Smaller values are stored exactly. Channel k uses period at byte offset 0x0C+12k and compare at 0x10+12k.
- R3: The control register at offset 0x08 holds one 4-bit field per channel, at bits 0, 8, 12 and 16 for channels 0 to 3. Field bit 0 is enable, bit 2 is invert and bit 3 is continuous mode. A channel counts only when both enable and continuous mode are 1. Otherwise its uninverted output is 0.
- R4: With period N > 0 and compare M < N on a channel ticking every cycle, the output repeats every N+1 ticks and is high for M+1 ticks of each repetition.
- R5: Period 0 gives a constantly low uninverted output. Compare ≥ period with period > 0 gives a constantly high uninverted output.
- R6: Invert complements the output in every state, so a stopped inverted channel drives 1.
- R7: Offset 0x14+12k reads channel k's counter, zero-extended. The counter changes only on clock edges where tick[k] is 1, and it decrements by one from a nonzero value. While the channel is stopped, the counter follows the period register.
- R8: Writes to the counter offsets, to 0x3C, 0x40 and 0x44–0x50, to undefined offsets and to any address with addr[1:0] ≠ 0 change nothing. Reads of 0x3C, 0x40, 0x44–0x50, undefined offsets and misaligned addresses return 0.
- R9: Offsets 0x00 (prescale) and 0x04 (clock select) store and return all 32 written bits. The control register also returns all 32 written bits.
- R10: A period or compare write to a running channel takes effect only when its counter next reloads from 0.
- R11: rdata is loaded on the clock edge where rd_en is 1 and holds its value on all other edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for addr/wdata |
| rd_en | input | 1 | Read strobe; rdata loads on this edge |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tick | input | 4 | Per-channel count enable from the prescaler |
| pwm_out | output | 4 | Channel outputs |

## Verification
The assertions assume that tick is a clean per-cycle enable and that rd_en, wr_en and addr are stable across each clock edge. The stimulus meets this by driving every input on the falling edge. The counter-step properties assume nothing else moves a running counter between ticks. For that reason the bench changes the control field only through the register port, never in the middle of a tick pulse that it measures. Duty and period are checked over windows that span whole periods. Each measurement starts only after enough ticks that any pending reload has happened.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
    localparam int CH_N      = 4;
    localparam int CNT_W     = 16;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int FLD_W     = 4;

    localparam int OFS_PRESCALE = 'h00;
    localparam int OFS_CLKSEL   = 'h04;
    localparam int OFS_CTRL     = 'h08;
    localparam int OFS_CH_FIRST = 'h0C;
    localparam int CH_STRIDE    = 12;
    localparam int SLOT_PERIOD  = 0;
    localparam int SLOT_COMPARE = 4;
    localparam int SLOT_COUNT   = 8;

    localparam int FB_EN     = 0;
    localparam int FB_INV    = 2;
    localparam int FB_TOGGLE = 3;

    typedef struct packed {
        logic en;
        logic inv;
        logic toggle;
    } ch_mode_t;

    function automatic int field_base(int k);
        return (k == 0) ? 0 : 4 + 4 * k;
    endfunction

    function automatic int chan_ofs(int k, int slot);
        return OFS_CH_FIRST + CH_STRIDE * k + slot;
    endfunction

    function automatic logic [CNT_W-1:0] saturate(logic [DATA_W-1:0] v);
        if (|v[DATA_W-1:CNT_W])
            return '1;
        return v[CNT_W-1:0];
    endfunction

    function automatic ch_mode_t mode_of(logic [DATA_W-1:0] ctrl, int k);
        logic [FLD_W-1:0] f;
        ch_mode_t m;
        f        = ctrl[field_base(k) +: FLD_W];
        m.en     = f[FB_EN];
        m.inv    = f[FB_INV];
        m.toggle = f[FB_TOGGLE];
        return m;
    endfunction
endpackage

// File: rtl/pwmq_regfile.sv
module pwmq_regfile
    import pwmq_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [CH_N-1:0][CNT_W-1:0]  cnt_vec,
    output logic [DATA_W-1:0]           rdata,
    output logic [CH_N-1:0][CNT_W-1:0]  period_vec,
    output logic [CH_N-1:0][CNT_W-1:0]  compare_vec,
    output logic [CH_N-1:0]             en_vec,
    output logic [CH_N-1:0]             inv_vec,
    output logic [CH_N-1:0]             tog_vec
);
    logic [DATA_W-1:0] prescale_q, clksel_q, ctrl_q;
    logic [DATA_W-1:0] rd_mux;
    logic [CH_N-1:0]   hit_per, hit_cmp, hit_cnt;
    logic              hit_pre, hit_csel, hit_ctl;

    always_comb begin
        hit_pre  = (addr == ADDR_W'(OFS_PRESCALE));
        hit_csel = (addr == ADDR_W'(OFS_CLKSEL));
        hit_ctl  = (addr == ADDR_W'(OFS_CTRL));
        for (int k = 0; k < CH_N; k++) begin
            hit_per[k] = (addr == ADDR_W'(chan_ofs(k, SLOT_PERIOD)));
            hit_cmp[k] = (addr == ADDR_W'(chan_ofs(k, SLOT_COMPARE)));
            hit_cnt[k] = (addr == ADDR_W'(chan_ofs(k, SLOT_COUNT)));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prescale_q  <= '0;
            clksel_q    <= '0;
            ctrl_q      <= '0;
            period_vec  <= '0;
            compare_vec <= '0;
        end else if (wr_en) begin
            if (hit_pre)  prescale_q <= wdata;
            if (hit_csel) clksel_q   <= wdata;
            if (hit_ctl)  ctrl_q     <= wdata;
            for (int k = 0; k < CH_N; k++) begin
                if (hit_per[k]) period_vec[k]  <= saturate(wdata);
                if (hit_cmp[k]) compare_vec[k] <= saturate(wdata);
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (hit_pre)  rd_mux = prescale_q;
        if (hit_csel) rd_mux = clksel_q;
        if (hit_ctl)  rd_mux = ctrl_q;
        for (int k = 0; k < CH_N; k++) begin
            if (hit_per[k]) rd_mux = DATA_W'(period_vec[k]);
            if (hit_cmp[k]) rd_mux = DATA_W'(compare_vec[k]);
            if (hit_cnt[k]) rd_mux = DATA_W'(cnt_vec[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end

    always_comb begin
        for (int k = 0; k < CH_N; k++) begin
            ch_mode_t m;
            m          = mode_of(ctrl_q, k);
            en_vec[k]  = m.en;
            inv_vec[k] = m.inv;
            tog_vec[k] = m.toggle;
        end
    end
endmodule

// File: rtl/pwmq_channel.sv
module pwmq_channel
    import pwmq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             en,
    input  logic             inv,
    input  logic             toggle,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] compare,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pwm_o
);
    logic             run;
    logic [CNT_W-1:0] cnt_q, act_per_q, act_cmp_q;
    logic             raw;

    assign run = en & toggle;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            act_per_q <= '0;
            act_cmp_q <= '0;
        end else if (!run || (tick && cnt_q == '0)) begin
            cnt_q     <= period;
            act_per_q <= period;
            act_cmp_q <= compare;
        end else if (tick) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        if (!run || act_per_q == '0)
            raw = 1'b0;
        else if (act_cmp_q >= act_per_q)
            raw = 1'b1;
        else
            raw = (cnt_q >= act_per_q - act_cmp_q);
    end

    assign pwm_o = raw ^ inv;
    assign cnt_o = cnt_q;
endmodule

// File: rtl/pwmq_ctrl.sv
module pwmq_ctrl
    import pwmq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [CH_N-1:0]   tick,
    output logic [CH_N-1:0]   pwm_out
);
    logic [CH_N-1:0][CNT_W-1:0] cnt_vec;
    logic [CH_N-1:0][CNT_W-1:0] period_vec;
    logic [CH_N-1:0][CNT_W-1:0] compare_vec;
    logic [CH_N-1:0]            en_vec, inv_vec, tog_vec;

    pwmq_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .cnt_vec    (cnt_vec),
        .rdata      (rdata),
        .period_vec (period_vec),
        .compare_vec(compare_vec),
        .en_vec     (en_vec),
        .inv_vec    (inv_vec),
        .tog_vec    (tog_vec)
    );

    for (genvar k = 0; k < CH_N; k++) begin : g_ch
        pwmq_channel u_ch (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick[k]),
            .en     (en_vec[k]),
            .inv    (inv_vec[k]),
            .toggle (tog_vec[k]),
            .period (period_vec[k]),
            .compare(compare_vec[k]),
            .cnt_o  (cnt_vec[k]),
            .pwm_o  (pwm_out[k])
        );
    end
endmodule

// File: rtl/pwmq_checker.sv
module pwmq_checker
    import pwmq_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       rd_en,
    input logic [DATA_W-1:0]          rdata,
    input logic [CH_N-1:0]            tick,
    input logic [CH_N-1:0]            pwm_out,
    input logic [CH_N-1:0][CNT_W-1:0] cnt_vec,
    input logic [CH_N-1:0]            en_vec,
    input logic [CH_N-1:0]            inv_vec,
    input logic [CH_N-1:0]            tog_vec
);
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pwm_out == '0 && rdata == '0));

    a_r11_read_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    for (genvar k = 0; k < CH_N; k++) begin : g_chk
        logic run;
        assign run = en_vec[k] & tog_vec[k];

        a_r3_stopped_idle: assert property (@(posedge clk) disable iff (rst)
            !run |-> (pwm_out[k] == inv_vec[k]));

        a_r7_count_hold: assert property (@(posedge clk) disable iff (rst)
            (run && !tick[k]) |=> (!run || $stable(cnt_vec[k])));

        a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
            (run && tick[k] && cnt_vec[k] != '0) |=>
                (!run || cnt_vec[k] == CNT_W'($past(cnt_vec[k]) - 1'b1)));
    end
endmodule

bind pwmq_ctrl pwmq_checker u_pwmq_checker (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rdata   (rdata),
    .tick    (tick),
    .pwm_out (pwm_out),
    .cnt_vec (cnt_vec),
    .en_vec  (en_vec),
    .inv_vec (inv_vec),
    .tog_vec (tog_vec)
);

// File: tb/pwmq_ctrl_test.sv
module pwmq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  tick = '0;
    logic [3:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    pwmq_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick(tick), .pwm_out(pwm_out)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 12'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = 12'(a);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    function automatic int fpos(int k);
        case (k)
            0: return 0;
            1: return 8;
            2: return 12;
            default: return 16;
        endcase
    endfunction

    function automatic logic [31:0] fld(int k, bit en, bit inv, bit tog);
        return 32'({tog, inv, 1'b0, en}) << fpos(k);
    endfunction

    int per_ofs[4] = '{'h0C, 'h18, 'h24, 'h30};

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 outputs", 32'(pwm_out), 0);
        for (int a = 0; a <= 'h54; a += 4) begin
            rd(a, v);
            check("R1 reset read", v, 0);
        end

        // R9 stored words
        wr('h00, 32'hDEADBEEF); wr('h04, 32'hA5A55A5A);
        rd('h00, v); check("R9 prescale", v, 32'hDEADBEEF);
        rd('h04, v); check("R9 clock select", v, 32'hA5A55A5A);
        wr('h08, 32'hF0F0_0000); rd('h08, v); check("R9 control", v, 32'hF0F0_0000);
        wr('h08, 0);

        // R2 saturation
        wr('h18, 32'h0001_0000); rd('h18, v); check("R2 period sat", v, 32'hFFFF);
        wr('h18, 32'h0000_1234); rd('h18, v); check("R2 period exact", v, 32'h1234);
        wr('h1C, 32'hFFFF_FFFF); rd('h1C, v); check("R2 compare sat", v, 32'hFFFF);
        wr('h1C, 32'h0000_FFFF); rd('h1C, v); check("R2 compare max", v, 32'hFFFF);

        // R8 ignored writes and zero reads
        wr('h0C, 0);
        foreach (per_ofs[i]) wr(per_ofs[i] + 8, 32'hFFFF_FFFF);
        rd('h14, v); check("R8 count write ignored", v, 0);
        for (int a = 'h3C; a <= 'h50; a += 4) begin
            wr(a, 32'hFFFF_FFFF);
            rd(a, v); check("R8 irq/wd reads 0", v, 0);
        end
        wr('h19, 32'h5); rd('h18, v); check("R8 misaligned write ignored", v, 32'h1234);
        rd('h1A, v); check("R8 misaligned read 0", v, 0);
        rd('h54, v); check("R8 undefined read 0", v, 0);
        wr('h200, 32'h7); rd('h00, v); check("R8 undefined write ignored", v, 32'hDEADBEEF);

        // R11 rdata holds without rd_en
        rd('h04, v);
        @(negedge clk); addr = 12'h000;
        repeat (3) @(negedge clk);
        check("R11 rdata hold", rdata, 32'hA5A55A5A);

        // R3 / R6 idle levels
        wr('h0C, 5); wr('h10, 9);
        wr('h08, fld(0, 1, 0, 0));
        tick = '1; repeat (8) @(negedge clk);
        check("R3 enable without mode idle", 32'(pwm_out), 0);
        wr('h08, fld(0, 0, 0, 1));
        repeat (4) @(negedge clk);
        check("R3 mode without enable idle", 32'(pwm_out), 0);
        wr('h08, fld(3, 0, 1, 0));
        @(negedge clk);
        check("R6 stopped inverted high", 32'(pwm_out), 32'h8);
        wr('h08, 0);

        // R4 R5 R6 R3 sweep
        for (int ch = 0; ch < 4; ch++) begin
            for (int n = 0; n <= 5; n++) begin
                for (int m = 0; m <= 6; m++) begin
                    bit inv;
                    int w, h, hi, edges, e_exp;
                    bit prev;
                    inv = ((n + m + ch) % 2) == 1;
                    w = n + 1;
                    h = (n == 0) ? 0 : ((m >= n) ? n + 1 : m + 1);
                    e_exp = (h > 0 && h < w) ? 4 : 0;
                    if (inv) h = w - h;
                    wr(per_ofs[ch], 32'(n));
                    wr(per_ofs[ch] + 4, 32'(m));
                    wr('h08, fld(ch, 1, inv, 1));
                    repeat (16) @(negedge clk);
                    hi = 0;
                    for (int c = 0; c < w; c++) begin
                        hi += pwm_out[ch];
                        @(negedge clk);
                    end
                    check((n == 0 || m >= n) ? "R5 constant duty" : "R4 duty high ticks", 32'(hi), 32'(h));
                    edges = 0;
                    prev = pwm_out[ch];
                    for (int c = 0; c < 4 * w; c++) begin
                        @(negedge clk);
                        if (!prev && pwm_out[ch]) edges++;
                        prev = pwm_out[ch];
                    end
                    check("R4 period N+1 ticks", 32'(edges), 32'(e_exp));
                    check("R3 other channels idle", 32'(pwm_out & ~(4'b1 << ch)), 0);
                end
            end
            wr('h08, 0);
        end

        // R7 counter and tick gating
        tick = '0;
        wr('h24, 9); wr('h28, 3);
        rd('h2C, v); check("R7 stopped count follows period", v, 9);
        wr('h08, fld(2, 1, 0, 1));
        rd('h2C, v);
        repeat (5) @(negedge clk);
        rd('h2C, v2);
        check("R7 no tick no count", v2, v);
        check("R7 start value", v2, 9);
        @(negedge clk); tick[2] = 1'b1;
        repeat (3) @(negedge clk); tick[2] = 1'b0;
        rd('h2C, v); check("R7 three ticks", v, 6);
        check("R4 high at last compare tick", 32'(pwm_out[2]), 1);
        @(negedge clk); tick[2] = 1'b1; @(negedge clk); tick[2] = 1'b0;
        check("R4 low after compare span", 32'(pwm_out[2]), 0);
        wr('h08, 0);

        // R10 deferred period
        wr('h18, 3); wr('h1C, 1);
        wr('h08, fld(1, 1, 0, 1));
        wr('h18, 7);
        rd('h20, v); check("R10 running count unchanged", v, 3);
        @(negedge clk); tick[1] = 1'b1;
        repeat (3) @(negedge clk); tick[1] = 1'b0;
        rd('h20, v); check("R10 reaches zero on old period", v, 0);
        @(negedge clk); tick[1] = 1'b1; @(negedge clk); tick[1] = 1'b0;
        rd('h20, v); check("R10 reload picks new period", v, 7);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule